// File: doc/BRIEF.md
# Two-Round Permutation Swap Resolver

This block merges two consecutive rounds of a byte-permutation stream cipher into one parallel update of the permutation state. It receives four indices (`i1`, `j1`, `i2`, `j2`) and the four state bytes read at those indices from the old state. It returns up to four write ports that move the state straight from the old state to the state after both rounds. Round one exchanges the entries at `i1` and `j1`. Round two then exchanges the entries at `i2` and `j2`. Every write value is taken from the old state only. The surrounding register bank can therefore apply all four writes on a single clock edge. The index arithmetic and the state storage lie outside this block.

Three equality comparisons pick the routing: `i2==j1`, `j2==i1` and `j2==j1`. Two more comparisons, `i1==j1` and `i2==j2`, collapse lanes that point at the same address, so that each address is written once. The caller always supplies `i2 = i1 + 1` modulo the state size, so `i2` never equals `i1`. The result is registered, one cycle after the request.

Top module: `pair_swap_resolver`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. While `out_valid` is low, `wr_en` is all zeros.
- R2: Write lane k uses `wr_addr[k*AW +: AW]` and `wr_data[k*DW +: DW]`. Lane 0 carries the address `i1`, lane 1 `j1`, lane 2 `i2` and lane 3 `j2`, each taken from the accepted request.
- R3: When no two of the four indices are equal, lanes 0 and 1 carry the old values at `j1` and `i1`, and lanes 2 and 3 carry the old values at `j2` and `i2`.
- R4: When only `j2==j1` holds among the index equalities, the new value at `i1` is the old value at `j1`. The new value at `j1` is the old value at `i2`, and the new value at `i2` is the old value at `i1`.
- R5: When `i2==j1` and `j2==i1`, every enabled lane writes back the old value stored at its own address, so the state is unchanged.
- R6: With `out_valid` high, lane 0 is always enabled. Each other lane is enabled only if its address differs from the addresses of all lower-numbered lanes. No two enabled lanes share an address.
- R7: For every legal alias pattern, including `i1==j1`, `i2==j2`, `j2==i1` alone and `i2==j1` alone, applying the enabled writes gives the same state as exchanging (`i1`,`j1`) and then (`i2`,`j2`) on the old state.
- R8: While `rst_n` is low, `out_valid` is 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| idx_i1 | input | AW | First-round fixed index |
| idx_j1 | input | AW | First-round moving index |
| idx_i2 | input | AW | Second-round fixed index, equal to `idx_i1+1` |
| idx_j2 | input | AW | Second-round moving index |
| rd_i1 | input | DW | Old state value at `idx_i1` |
| rd_j1 | input | DW | Old state value at `idx_j1` |
| rd_i2 | input | DW | Old state value at `idx_i2` |
| rd_j2 | input | DW | Old state value at `idx_j2` |
| out_valid | output | 1 | Write set valid |
| wr_en | output | 4 | Per-lane write enable |
| wr_addr | output | 4*AW | Per-lane write address, lane k at bits k*AW |
| wr_data | output | 4*DW | Per-lane write data, lane k at bits k*DW |

## Verification
The two rounds' exchanges fall in the same cycle. Whenever round two's indices alias round one's, the routing is redirected and duplicate lanes are suppressed. The bench provokes every alias pattern with directed index sets, then with random sets biased so that `j1` and `j2` often land on `i1`, `i2` or each other. After each request it applies the enabled writes to a mirror array and compares the whole array with one where the two exchanges were done one after the other. It also checks that no two enabled lanes share an address.

// File: rtl/pair_swap_pkg.sv
package pair_swap_pkg;

  typedef enum logic [1:0] {
    SRC_I1 = 2'd0,
    SRC_J1 = 2'd1,
    SRC_I2 = 2'd2,
    SRC_J2 = 2'd3
  } src_e;

  typedef struct packed {
    logic i2_j1;
    logic j2_i1;
    logic j2_j1;
  } alias_t;

  localparam int NLANE = 4;

  // value of the second-round fixed slot after round one
  function automatic src_e mid_i2(alias_t a);
    return a.i2_j1 ? SRC_I1 : SRC_I2;
  endfunction

  // value of the second-round moving slot after round one
  function automatic src_e mid_j2(alias_t a);
    if (a.j2_j1) return SRC_I1;
    if (a.j2_i1) return SRC_J1;
    return SRC_J2;
  endfunction

  // lanes: 0=i1, 1=j1, 2=i2, 3=j2
  function automatic src_e lane_src(int lane, alias_t a);
    case (lane)
      0: return a.j2_i1 ? mid_i2(a) : SRC_J1;
      1: begin
        if (a.i2_j1) return mid_j2(a);
        if (a.j2_j1) return SRC_I2;
        return SRC_I1;
      end
      2: return mid_j2(a);
      default: return mid_i2(a);
    endcase
  endfunction

  function automatic logic lane_enable(int lane, alias_t a, logic i1_j1, logic i2_j2);
    case (lane)
      0: return 1'b1;
      1: return !i1_j1;
      2: return !a.i2_j1;
      default: return !(a.j2_i1 || a.j2_j1 || i2_j2);
    endcase
  endfunction

endpackage

// File: rtl/pair_alias_cmp.sv
module pair_alias_cmp
  import pair_swap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] i1,
  input  logic [AW-1:0] j1,
  input  logic [AW-1:0] i2,
  input  logic [AW-1:0] j2,
  output alias_t        flags,
  output logic          i1_j1,
  output logic          i2_j2
);
  always_comb begin
    flags.i2_j1 = (i2 == j1);
    flags.j2_i1 = (j2 == i1);
    flags.j2_j1 = (j2 == j1);
    i1_j1       = (i1 == j1);
    i2_j2       = (i2 == j2);
  end
endmodule

// File: rtl/pair_lane_mux.sv
module pair_lane_mux
  import pair_swap_pkg::*;
#(
  parameter int DW   = 8,
  parameter int LANE = 0
) (
  input  alias_t        flags,
  input  logic [DW-1:0] v_i1,
  input  logic [DW-1:0] v_j1,
  input  logic [DW-1:0] v_i2,
  input  logic [DW-1:0] v_j2,
  output logic [DW-1:0] dout
);
  src_e sel;
  always_comb begin
    sel = lane_src(LANE, flags);
    case (sel)
      SRC_I1:  dout = v_i1;
      SRC_J1:  dout = v_j1;
      SRC_I2:  dout = v_i2;
      default: dout = v_j2;
    endcase
  end
endmodule

// File: rtl/pair_swap_resolver.sv
module pair_swap_resolver
  import pair_swap_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [AW-1:0]       idx_i1,
  input  logic [AW-1:0]       idx_j1,
  input  logic [AW-1:0]       idx_i2,
  input  logic [AW-1:0]       idx_j2,
  input  logic [DW-1:0]       rd_i1,
  input  logic [DW-1:0]       rd_j1,
  input  logic [DW-1:0]       rd_i2,
  input  logic [DW-1:0]       rd_j2,
  output logic                out_valid,
  output logic [NLANE-1:0]    wr_en,
  output logic [NLANE*AW-1:0] wr_addr,
  output logic [NLANE*DW-1:0] wr_data
);
  localparam int ABUS = NLANE * AW;
  localparam int DBUS = NLANE * DW;

  alias_t           flags;
  logic             i1_j1;
  logic             i2_j2;
  logic [ABUS-1:0]  addr_c;
  logic [DBUS-1:0]  data_c;
  logic [NLANE-1:0] en_c;

  pair_alias_cmp #(.AW(AW)) u_cmp (
    .i1(idx_i1), .j1(idx_j1), .i2(idx_i2), .j2(idx_j2),
    .flags(flags), .i1_j1(i1_j1), .i2_j2(i2_j2)
  );

  assign addr_c = {idx_j2, idx_i2, idx_j1, idx_i1};

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    pair_lane_mux #(.DW(DW), .LANE(k)) u_mux (
      .flags(flags),
      .v_i1(rd_i1), .v_j1(rd_j1), .v_i2(rd_i2), .v_j2(rd_j2),
      .dout(data_c[k*DW +: DW])
    );
    assign en_c[k] = in_valid && lane_enable(k, flags, i1_j1, i2_j2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= en_c;
      wr_addr   <= addr_c;
      wr_data   <= data_c;
    end
  end

  // R1: valid follows request by one cycle, idle means no writes
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (wr_en == '0));
  // R6: first lane always written, no two enabled lanes share an address
  p_lane0_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wr_en[0]);
  for (genvar a = 0; a < NLANE; a++) begin : g_pa
    for (genvar b = a + 1; b < NLANE; b++) begin : g_pb
      p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[a] && wr_en[b]) |-> (wr_addr[a*AW +: AW] != wr_addr[b*AW +: AW]));
    end
  end
  // R5: cancelling pair keeps the old values
  p_cancel_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_i2 == idx_j1 && idx_j2 == idx_i1)
      |=> (wr_data[0 +: DW] == $past(rd_i1)));
  // R4: rotation when only the moving indices coincide
  p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_j2 == idx_j1 && idx_i2 != idx_j1 && idx_j2 != idx_i1
      && idx_i1 != idx_j1)
      |=> (wr_data[DW +: DW] == $past(rd_i2) && wr_data[2*DW +: DW] == $past(rd_i1)));
  // R8: reset quiets outputs
  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_valid && wr_en == '0));
endmodule

// File: tb/test_pair_swap_resolver.sv
module test_pair_swap_resolver;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N  = 256;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [AW-1:0] idx_i1 = 0, idx_j1 = 0, idx_i2 = 0, idx_j2 = 0;
  logic [DW-1:0] rd_i1 = 0, rd_j1 = 0, rd_i2 = 0, rd_j2 = 0;
  logic out_valid;
  logic [3:0] wr_en;
  logic [4*AW-1:0] wr_addr;
  logic [4*DW-1:0] wr_data;

  int checks = 0;
  int failures = 0;
  int bank[N];
  int ref_s[N];
  bit done = 0;
  int cycles = 0;

  pair_swap_resolver #(.AW(AW), .DW(DW)) i_pair_swap_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .idx_i1(idx_i1), .idx_j1(idx_j1), .idx_i2(idx_i2), .idx_j2(idx_j2),
    .rd_i1(rd_i1), .rd_j1(rd_j1), .rd_i2(rd_i2), .rd_j2(rd_j2),
    .out_valid(out_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_pair(int i1, int j1, int j2);
    int i2;
    string tag;
    bit ea, eb, ec, dup;
    int bad, bad_at, t;
    i2 = (i1 + 1) % N;
    ea = (i2 == j1); eb = (j2 == i1); ec = (j2 == j1);
    if (ea && eb) tag = "R5";
    else if (ec && !ea && !eb && i1 != j1) tag = "R4";
    else if (!ea && !eb && !ec && i1 != j1 && i2 != j2) tag = "R3";
    else tag = "R7";
    @(negedge clk);
    idx_i1 = AW'(i1); idx_j1 = AW'(j1); idx_i2 = AW'(i2); idx_j2 = AW'(j2);
    rd_i1 = DW'(bank[i1]); rd_j1 = DW'(bank[j1]);
    rd_i2 = DW'(bank[i2]); rd_j2 = DW'(bank[j2]);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1'b1, "R1", "out_valid after request", int'(out_valid), 1);
    check(wr_en[0] == 1'b1, "R6", "lane0 enable", int'(wr_en[0]), 1);
    check(int'(wr_addr[0 +: AW]) == i1 && int'(wr_addr[AW +: AW]) == j1 &&
          int'(wr_addr[2*AW +: AW]) == i2 && int'(wr_addr[3*AW +: AW]) == j2,
          "R2", "lane addresses", int'(wr_addr), 0);
    dup = 0;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (wr_en[a] && wr_en[b] && wr_addr[a*AW +: AW] == wr_addr[b*AW +: AW]) dup = 1;
    check(!dup, "R6", "duplicate enabled address", int'(wr_en), 0);
    for (int k = 0; k < 4; k++)
      if (wr_en[k]) bank[int'(wr_addr[k*AW +: AW])] = int'(wr_data[k*DW +: DW]);
    t = ref_s[i1]; ref_s[i1] = ref_s[j1]; ref_s[j1] = t;
    t = ref_s[i2]; ref_s[i2] = ref_s[j2]; ref_s[j2] = t;
    bad = 0; bad_at = 0;
    for (int k = 0; k < N; k++)
      if (bank[k] != ref_s[k]) begin
        if (bad == 0) bad_at = k;
        bad++;
      end
    check(bad == 0, tag, $sformatf("state after pair (%0d,%0d,%0d,%0d) at %0d",
          i1, j1, i2, j2, bad_at), bank[bad_at], ref_s[bad_at]);
    @(negedge clk);
    check(out_valid == 1'b0 && wr_en == 4'b0, "R1", "idle after request",
          int'(wr_en), 0);
  endtask

  function automatic int pick(int a, int b, int c);
    case ($urandom % 5)
      0: return a;
      1: return b;
      2: return c;
      default: return int'($urandom % N);
    endcase
  endfunction

  initial begin
    for (int k = 0; k < N; k++) begin bank[k] = k; ref_s[k] = k; end
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && wr_en == 4'b0, "R8", "reset outputs", int'(wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "idle before requests", int'(out_valid), 0);
    do_pair(1, 40, 90);    // R3 no aliasing
    do_pair(3, 77, 77);    // R4 j2==j1 only
    do_pair(5, 6, 5);      // R5 cancel
    do_pair(7, 7, 100);    // R7 i1==j1
    do_pair(9, 30, 10);    // R7 i2==j2
    do_pair(11, 50, 11);   // R7 j2==i1 only
    do_pair(13, 14, 60);   // R7 i2==j1 only
    do_pair(15, 16, 16);   // R7 i2==j1 and j2==j1
    do_pair(17, 17, 17);   // R7 i1==j1==j2
    do_pair(255, 0, 255);  // R5 wraparound cancel
    do_pair(255, 9, 9);    // R4 wraparound index
    for (int n = 0; n < 400; n++) begin
      int i1, j1, j2;
      i1 = (2 * n + 1) % N;
      j1 = pick(i1, (i1 + 1) % N, int'($urandom % N));
      j2 = pick(i1, (i1 + 1) % N, j1);
      do_pair(i1, j1, j2);
    end
    finish_run();
  end
endmodule